// File: doc/BRIEF.md
# Overcurrent Fault Timer with Cooldown

This block is the digital timing core of a hot-swap power switch controller. An upstream current-limit loop raises `oc_active_i` while it is actively limiting load current. While that flag is high, an internal 16-bit accumulator climbs by a large step on each clock. If the accumulator reaches the trip level, the block removes gate enable and emits a one-cycle fault pulse. It then enters a cooldown in which the accumulator falls by a small step on each clock, whatever the overcurrent input does. When the value drops below the clear level, the block leaves cooldown and the switch may be turned on again. The charge step is fifty times the discharge step, so a short overload costs a long rest.

A controller FSM has three states. `ST_IDLE` means gate off and not cooling. `ST_ON` means gate on. `ST_COOL` means tripped and discharging. The transitions are:
- `T_ARM`: `ST_IDLE`→`ST_ON` when the enable request is high.
- `T_DROP`: `ST_ON`→`ST_IDLE` when the request is low.
- `T_TRIP`: `ST_IDLE` or `ST_ON`→`ST_COOL` when the next accumulator value reaches the trip level. This transition takes priority over the other two.
- `T_COOLED`: `ST_COOL`→`ST_IDLE` when the next accumulator value falls below the clear level.

All outputs are registered. They reflect the state entered at the most recent clock edge.

Top module: `oc_fault_timer`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), and on the first cycle after reset, `gate_en_o`, `fault_o` and `busy_o` are 0 and the accumulator is 0.
- R2: Outside cooldown, each clock edge with `oc_active_i` high adds `UP_STEP` (default 50) to the accumulator. The add saturates at the all-ones value. With defaults and trip level T, a fault follows exactly ceil(T/50) consecutive overcurrent edges starting from an empty accumulator.
- R3: When the accumulator value produced at an edge outside cooldown is at least `TRIP_LEVEL`, the following all happen after that same edge: `gate_en_o` is 0, `fault_o` is 1 for exactly one cycle, and `busy_o` rises.
- R4: In cooldown the accumulator falls by `DOWN_STEP` (default 1) per edge. `busy_o` stays high until the edge whose new value is below `CLEAR_LEVEL`, then falls. With a trip entered at value A, `busy_o` is high for A − `CLEAR_LEVEL` + 1 cycles.
- R5: During cooldown `oc_active_i` is ignored. The accumulator keeps falling, so the cooldown length is unchanged whether the input is held high or low.
- R6: During cooldown `en_req_i` is ignored. `gate_en_o` stays 0 while `busy_o` is 1.
- R7: The edge that ends cooldown leaves `gate_en_o` at 0. With `en_req_i` high, `gate_en_o` rises one edge later, unless a new trip occurs first.
- R8: Outside cooldown, an edge with `oc_active_i` low lowers the accumulator by `DOWN_STEP`, floored at 0. The residue shortens the next path to a trip: after 10 overcurrent edges followed by 100 quiet edges, 16 further overcurrent edges trip when the trip level is 1200.
- R9: Outside cooldown and without a trip, `gate_en_o` follows `en_req_i` with a delay of one edge (`T_ARM`, `T_DROP`).
- R10: `fault_o` is never high except on the cycle right after a `T_TRIP` edge. Two consecutive cycles never both show `fault_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_active_i | input | 1 | Current limit loop is actively limiting |
| en_req_i | input | 1 | Request to turn the pass switch on |
| gate_en_o | output | 1 | Pass switch gate enable |
| fault_o | output | 1 | One-cycle pulse on an overcurrent trip |
| busy_o | output | 1 | Cooldown in progress |

## Verification
The hardest case to reach from the ports is a trip that starts from a partly charged accumulator. The accumulator is not visible, so its residue can only be inferred from when the next fault arrives. The bench reaches this case directly with an interrupted burst, then quiet cycles, then a new burst, and checks the exact trip cycle. Random overcurrent bursts of varied length, mixed with toggling enable requests, then land trips at many residue values and at every state, including trips taken from `ST_IDLE`. Cooldowns are also driven with overcurrent and enable held high throughout, to show that both inputs are ignored.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_COOL = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic gate;
        logic fault;
        logic busy;
    } tmr_out_t;

endpackage

// File: rtl/oc_acc_ramp.sv
module oc_acc_ramp #(
    parameter int ACC_W     = 16,
    parameter int UP_STEP   = 50,
    parameter int DOWN_STEP = 1,
    parameter bit SATURATE  = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             charge_i,
    output logic [ACC_W-1:0] acc_q_o,
    output logic [ACC_W-1:0] acc_n_o
);

    localparam logic [ACC_W-1:0] UP_V   = ACC_W'(UP_STEP);
    localparam logic [ACC_W-1:0] DOWN_V = ACC_W'(DOWN_STEP);
    localparam logic [ACC_W-1:0] TOP_V  = {ACC_W{1'b1}};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum_w;
    logic [ACC_W-1:0] up_val;
    logic [ACC_W-1:0] down_val;

    assign sum_w = {1'b0, acc_q} + {1'b0, UP_V};

    generate
        if (SATURATE) begin : g_sat
            assign up_val = sum_w[ACC_W] ? TOP_V : sum_w[ACC_W-1:0];
        end else begin : g_wrap
            assign up_val = sum_w[ACC_W-1:0];
        end
    endgenerate

    assign down_val = (acc_q >= DOWN_V) ? (acc_q - DOWN_V) : '0;
    assign acc_n_o  = charge_i ? up_val : down_val;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_n_o;
        end
    end

    assign acc_q_o = acc_q;

endmodule

// File: rtl/oc_level_cmp.sv
module oc_level_cmp #(
    parameter int ACC_W       = 16,
    parameter int TRIP_LEVEL  = 12000,
    parameter int CLEAR_LEVEL = 2000
) (
    input  logic [ACC_W-1:0] level_i,
    output logic             at_trip_o,
    output logic             below_clear_o
);

    localparam logic [ACC_W-1:0] TRIP_V  = ACC_W'(TRIP_LEVEL);
    localparam logic [ACC_W-1:0] CLEAR_V = ACC_W'(CLEAR_LEVEL);

    assign at_trip_o     = (level_i >= TRIP_V);
    assign below_clear_o = (level_i <  CLEAR_V);

endmodule

// File: rtl/oc_timer_fsm.sv
module oc_timer_fsm
    import oc_timer_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     en_req_i,
    input  logic     at_trip_i,
    input  logic     below_clear_i,
    output logic     cooling_o,
    output tmr_out_t out_o
);

    tmr_state_e state_q;
    tmr_state_e state_n;
    logic       trip_now;
    tmr_out_t   out_q;

    assign cooling_o = (state_q == ST_COOL);
    assign trip_now  = (state_q != ST_COOL) && at_trip_i;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (at_trip_i) begin
                    state_n = ST_COOL;
                end else if (en_req_i) begin
                    state_n = ST_ON;
                end
            end
            ST_ON: begin
                if (at_trip_i) begin
                    state_n = ST_COOL;
                end else if (!en_req_i) begin
                    state_n = ST_IDLE;
                end
            end
            ST_COOL: begin
                if (below_clear_i) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q.gate  <= (state_n == ST_ON);
            out_q.busy  <= (state_n == ST_COOL);
            out_q.fault <= trip_now;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/oc_fault_timer.sv
module oc_fault_timer
    import oc_timer_pkg::*;
#(
    parameter int ACC_W       = 16,
    parameter int UP_STEP     = 50,
    parameter int DOWN_STEP   = 1,
    parameter int TRIP_LEVEL  = 12000,
    parameter int CLEAR_LEVEL = 2000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic oc_active_i,
    input  logic en_req_i,
    output logic gate_en_o,
    output logic fault_o,
    output logic busy_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_n;
    logic             cooling;
    logic             charge;
    logic             at_trip;
    logic             below_clear;
    tmr_out_t         outs;

    assign charge = oc_active_i && !cooling;

    oc_acc_ramp #(
        .ACC_W    (ACC_W),
        .UP_STEP  (UP_STEP),
        .DOWN_STEP(DOWN_STEP),
        .SATURATE (1'b1)
    ) u_ramp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .charge_i(charge),
        .acc_q_o (acc_q),
        .acc_n_o (acc_n)
    );

    oc_level_cmp #(
        .ACC_W      (ACC_W),
        .TRIP_LEVEL (TRIP_LEVEL),
        .CLEAR_LEVEL(CLEAR_LEVEL)
    ) u_cmp (
        .level_i      (acc_n),
        .at_trip_o    (at_trip),
        .below_clear_o(below_clear)
    );

    oc_timer_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_req_i     (en_req_i),
        .at_trip_i    (at_trip),
        .below_clear_i(below_clear),
        .cooling_o    (cooling),
        .out_o        (outs)
    );

    assign gate_en_o = outs.gate;
    assign fault_o   = outs.fault;
    assign busy_o    = outs.busy;

endmodule

// File: rtl/oc_fault_timer_checks.sv
module oc_fault_timer_checks #(
    parameter int ACC_W     = 16,
    parameter int UP_STEP   = 50,
    parameter int DOWN_STEP = 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             oc_active_i,
    input logic             en_req_i,
    input logic             gate_en_o,
    input logic             fault_o,
    input logic             busy_o,
    input logic [ACC_W-1:0] acc_q
);

    localparam logic [ACC_W-1:0] UP_V   = ACC_W'(UP_STEP);
    localparam logic [ACC_W-1:0] DOWN_V = ACC_W'(DOWN_STEP);

    assert_charge_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oc_active_i && !busy_o && !fault_o) |=> (acc_q == $past(acc_q) + UP_V));

    assert_fault_opens_cool_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (busy_o && !gate_en_o));

    assert_busy_rise_has_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> fault_o);

    assert_cool_discharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> (acc_q == $past(acc_q) - DOWN_V));

    assert_gate_off_cooling_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !gate_en_o);

    assert_exit_gate_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> !gate_en_o);

    assert_gate_rise_requested_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_en_o) |-> $past(en_req_i));

    assert_fault_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> !fault_o);

endmodule

bind oc_fault_timer oc_fault_timer_checks #(
    .ACC_W    (ACC_W),
    .UP_STEP  (UP_STEP),
    .DOWN_STEP(DOWN_STEP)
) u_checks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .oc_active_i(oc_active_i),
    .en_req_i   (en_req_i),
    .gate_en_o  (gate_en_o),
    .fault_o    (fault_o),
    .busy_o     (busy_o),
    .acc_q      (acc_q)
);

// File: tb/test_oc_fault_timer.sv
module test_oc_fault_timer;

    localparam int W     = 16;
    localparam int UP    = 50;
    localparam int DOWN  = 1;
    localparam int TRIP  = 1200;
    localparam int CLEAR = 200;
    localparam int MAXV  = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc = 1'b0;
    logic en = 1'b0;
    logic gate, fault, busy;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;

    int m_state = 0;
    int m_acc = 0;
    bit m_gate = 0, m_fault = 0, m_busy = 0;

    always #2 clk = ~clk;

    oc_fault_timer #(
        .ACC_W(W), .UP_STEP(UP), .DOWN_STEP(DOWN),
        .TRIP_LEVEL(TRIP), .CLEAR_LEVEL(CLEAR)
    ) i_oc_fault_timer (
        .clk_i(clk), .rst_ni(rst_n), .oc_active_i(oc), .en_req_i(en),
        .gate_en_o(gate), .fault_o(fault), .busy_o(busy)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int next_acc(input int st, input int acc, input bit o);
        int v;
        if (st != 2 && o) begin
            v = acc + UP;
            if (v > MAXV) v = MAXV;
        end else begin
            v = (acc >= DOWN) ? acc - DOWN : 0;
        end
        return v;
    endfunction

    function automatic int next_state(input int st, input int nacc, input bit e);
        if (st == 2) return (nacc < CLEAR) ? 0 : 2;
        if (nacc >= TRIP) return 2;
        return e ? 1 : 0;
    endfunction

    task automatic model_edge();
        int na, ns;
        na = next_acc(m_state, m_acc, oc);
        ns = next_state(m_state, na, en);
        m_fault = (m_state != 2) && (na >= TRIP);
        m_gate  = (ns == 1);
        m_busy  = (ns == 2);
        m_state = ns;
        m_acc   = na;
    endtask

    task automatic step(input bit o, input bit e);
        oc = o;
        en = e;
        model_edge();
        @(negedge clk);
        check(gate == m_gate, "R9 gate_en", int'(gate), int'(m_gate));
        check(fault == m_fault, "R10 fault", int'(fault), int'(m_fault));
        check(busy == m_busy, "R4 busy", int'(busy), int'(m_busy));
    endtask

    initial begin
        int n;
        int r;
        int burst;
        r = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1 reset values during reset
        check(gate == 0 && fault == 0 && busy == 0, "R1 reset outputs",
              int'({gate, fault, busy}), 0);
        rst_n = 1'b1;
        step(0, 0);
        check(gate == 0 && fault == 0 && busy == 0, "R1 after reset",
              int'({gate, fault, busy}), 0);

        // R9: arm and drop
        step(0, 1);
        check(gate == 1, "R9 T_ARM", int'(gate), 1);
        step(0, 1);
        step(0, 0);
        check(gate == 0, "R9 T_DROP", int'(gate), 0);

        // R2/R3: full charge from empty, request held
        repeat (5) step(0, 1);
        n = 0;
        while (!fault && n < 100) begin
            step(1, 1);
            n++;
        end
        check(n == 24, "R2 edges to trip", n, 24);
        check(gate == 0 && busy == 1, "R3 trip drops gate", int'({gate, busy}), 1);

        // R4/R5/R6: cooldown with overcurrent and request held high
        n = 1;
        while (busy && n < 5000) begin
            step(1, 1);
            if (busy) n++;
            if (busy) check(gate == 0, "R6 gate off in cooldown", int'(gate), 0);
        end
        check(n == 1001, "R5 cooldown length with oc held", n, 1001);
        check(gate == 0, "R7 exit leaves gate low", int'(gate), 0);
        step(0, 1);
        check(gate == 1, "R7 gate returns after cooldown", int'(gate), 1);

        // drain residue, then second cooldown with inputs low
        repeat (250) step(0, 0);
        n = 0;
        while (!fault && n < 100) begin
            step(1, 0);
            n++;
        end
        check(n == 24, "R3 trip from ST_IDLE", n, 24);
        n = 1;
        while (busy && n < 5000) begin
            step(0, 0);
            if (busy) n++;
        end
        check(n == 1001, "R4 cooldown length with oc low", n, 1001);

        // R8: residue after interrupted burst
        repeat (250) step(0, 1);
        repeat (10) step(1, 1);
        check(fault == 0 && gate == 1, "R8 partial burst no trip", int'(fault), 0);
        repeat (100) step(0, 1);
        n = 0;
        while (!fault && n < 100) begin
            step(1, 1);
            n++;
        end
        check(n == 16, "R8 edges to trip with residue", n, 16);
        while (busy) step(0, 0);

        // random bursts and request toggles
        burst = 0;
        for (int i = 0; i < 6000; i++) begin
            bit o, e;
            e = en;
            if (($urandom % 100) < 2) e = ~e;
            if (burst > 0) begin
                burst--;
                o = 1'b1;
            end else begin
                o = 1'b0;
                if (($urandom % 100) < 4) burst = 1 + ($urandom % 40);
            end
            step(o, e);
        end

        // R1: reset in the middle of activity
        repeat (30) step(1, 1);
        rst_n = 1'b0;
        m_state = 0; m_acc = 0;
        m_gate = 0; m_fault = 0; m_busy = 0;
        @(negedge clk);
        check(gate == 0 && fault == 0 && busy == 0, "R1 mid-run reset",
              int'({gate, fault, busy}), 0);
        rst_n = 1'b1;
        n = 0;
        while (!fault && n < 100) begin
            step(1, 1);
            n++;
        end
        check(n == 24, "R1 accumulator cleared by reset", n, 24);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule